// File: doc/BRIEF.md
# Local Counter Mirror Scanner

This block runs in the background and copies the fast, on-chip statistics state into external memory. The state it walks is the local counter store, 512 words organised as 128 groups of four, and a separate 64-word system register bank. It visits that state in fixed eight-word pieces, one piece at a time, and turns each piece into an eight-beat burst write on an external memory port. A sweep is one pass over both stores. After the last piece the sweep starts again, so each word is refreshed at a steady rate.

A programmable interval timer sets the pace. The interval is chosen so that every word reaches external memory several times per second. The scanner shares the local store read port with the foreground update engine. The update engine wins every conflict. The scanner then holds its place and reads the same word again later, so no word is lost. A new piece is not started until the external memory confirms the previous burst. A one-cycle pulse marks the end of each complete sweep.

Top module: `stat_mirror_scanner`

## Requirements
- R1: While `rst_n` is low, `st_rd_en`, `ext_wvalid` and `sweep_done` are 0. The first piece read after reset is piece 0.
- R2: The interval timer ticks once every `interval_cycles` clocks, and a value of 0 counts as 1. The first tick comes in the cycle in which `interval_cycles`−1 rising edges have passed since reset was released. A piece may start only on a tick that has not yet been used. If the scanner is idle when a tick occurs, the first local read of the new piece happens two cycles after that tick.
- R3: Pieces are numbered 0 to 71. A piece p below 64 reads the counter store (`st_rd_bank`=0) at words 8p to 8p+7. A piece p of 64 or more reads the register bank (`st_rd_bank`=1) at words 8(p−64) to 8(p−64)+7. Words are read in rising order, and the piece after 71 is 0.
- R4: `st_rd_en` is never high in a cycle where `fg_busy` is high. A blocked read is retried until it completes, and no word of a piece is skipped.
- R5: A burst is eight consecutive cycles of `ext_wvalid`, with `ext_wlast` high only on the eighth. Beat k carries the word returned for read k of the same piece. `st_rd_data` is taken as valid one cycle after `st_rd_en`.
- R6: `ext_waddr` equals `ext_base` + 8 × piece number, modulo 2^24. It is held constant for all eight beats of the burst.
- R7: After a burst, the scanner issues no local read and no burst until `ext_ack` is sampled high. An `ext_ack` that arrives while no burst is waiting has no effect.
- R8: `sweep_done` is high for exactly one cycle, in the cycle after the acknowledge of piece 71 is accepted. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval_cycles | input | 24 | Number of cycles between timer ticks; 0 counts as 1 |
| ext_base | input | 24 | External word address that piece 0 is written to |
| fg_busy | input | 1 | Foreground engine holds the local read port this cycle |
| st_rd_en | output | 1 | Scanner read strobe to the local stores |
| st_rd_bank | output | 1 | Store select: 0 is the counter store, 1 is the register bank |
| st_rd_addr | output | 9 | Word address within the selected store |
| st_rd_data | input | 32 | Read data, valid the cycle after `st_rd_en` |
| ext_wvalid | output | 1 | Burst beat valid |
| ext_waddr | output | 24 | Start address of the burst, held for all beats |
| ext_wdata | output | 32 | Beat data |
| ext_wlast | output | 1 | Final beat of the burst |
| ext_ack | input | 1 | External memory confirms that the burst is complete |
| sweep_done | output | 1 | One-cycle pulse at the end of each full sweep |

## Verification
The in-line assertions check on every cycle the properties that hold locally. They cover the spacing between timer ticks and the rule that the scanner stays idle without a pending tick. They also cover the frozen read position under foreground contention, the address held during a burst, the wait for acknowledge and the single-cycle sweep pulse. Only the bench scenarios show the properties that span a whole piece or sweep. These are the exact start cycle relative to the tick, the full visiting order with its wrap from the register bank back to counter word 0, and beat data matching the values read even while the store contents change. They also cover rejection of stray acknowledges and the address wrapping modulo 2^24 near the top of the external space.

// File: rtl/sms_pkg.sv
package sms_pkg;

   typedef enum logic [1:0] {
      SC_IDLE  = 2'd0,
      SC_READ  = 2'd1,
      SC_BURST = 2'd2,
      SC_WAIT  = 2'd3
   } scan_state_e;

   function automatic int larger_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sms_pacer.sv
module sms_pacer #(
   parameter int IW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] interval,
   output logic          tick
);

   logic [IW-1:0] tcnt;
   logic [IW-1:0] span;

   assign span = (interval == '0) ? IW'(1) : interval;
   assign tick = (tcnt >= span - IW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tcnt <= '0;
      else if (tick) tcnt <= '0;
      else           tcnt <= tcnt + IW'(1);
   end

   // R2: with a span above one, two ticks never fall on adjacent cycles
   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && interval > IW'(1)) |=> !tick);

endmodule

// File: rtl/sms_chunk_reader.sv
module sms_chunk_reader #(
   parameter int DW     = 32,
   parameter int CHUNK  = 8,
   parameter int NCH_C  = 64,
   parameter int NCH_R  = 8,
   parameter int CW     = 7,
   parameter int LAW    = 9
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       active,
   input  logic [CW-1:0]              chunk,
   input  logic                       fg_busy,
   input  logic [DW-1:0]              st_rd_data,
   output logic                       st_rd_en,
   output logic                       st_rd_bank,
   output logic [LAW-1:0]             st_rd_addr,
   output logic                       done,
   output logic [CHUNK-1:0][DW-1:0]   words
);

   localparam int CHW = $clog2(CHUNK);
   localparam logic [CHW:0] FULL = (CHW+1)'(CHUNK);

   logic [CHW:0]   issued;
   logic           cap_vld;
   logic [CHW-1:0] cap_idx;
   logic [CW-1:0]  rel;
   logic           wants;

   generate
      if (NCH_R > 0) begin : g_two_banks
         logic in_regs;
         assign in_regs    = (chunk >= CW'(NCH_C));
         assign st_rd_bank = in_regs;
         assign rel        = in_regs ? (chunk - CW'(NCH_C)) : chunk;
      end else begin : g_one_bank
         assign st_rd_bank = 1'b0;
         assign rel        = chunk;
      end
   endgenerate

   assign wants      = active && (issued < FULL);
   assign st_rd_en   = wants && !fg_busy;
   assign st_rd_addr = LAW'({rel, issued[CHW-1:0]});
   assign done       = active && (issued == FULL) && !cap_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issued  <= '0;
         cap_vld <= 1'b0;
         cap_idx <= '0;
         words   <= '0;
      end else begin
         cap_vld <= st_rd_en;
         cap_idx <= issued[CHW-1:0];
         if (!active)       issued <= '0;
         else if (st_rd_en) issued <= issued + (CHW+1)'(1);
         if (cap_vld)       words[cap_idx] <= st_rd_data;
      end
   end

   // R4: the read position never runs past the end of a piece
   p_issue_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issued <= FULL);
   // R4: while the foreground holds the port, the read position is frozen
   p_hold_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && fg_busy) |=> issued == $past(issued));
   // R5: every granted read is captured in the following cycle
   p_capture_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd_en |=> cap_vld);

endmodule

// File: rtl/sms_burst_writer.sv
module sms_burst_writer #(
   parameter int DW    = 32,
   parameter int CHUNK = 8,
   parameter int CW    = 7,
   parameter int EAW   = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     active,
   input  logic [CW-1:0]            chunk,
   input  logic [EAW-1:0]           ext_base,
   input  logic [CHUNK-1:0][DW-1:0] words,
   output logic                     ext_wvalid,
   output logic [EAW-1:0]           ext_waddr,
   output logic [DW-1:0]            ext_wdata,
   output logic                     ext_wlast,
   output logic                     burst_end
);

   localparam int CHW = $clog2(CHUNK);

   logic [CHW-1:0] beat;
   logic [EAW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat   <= '0;
         addr_q <= '0;
      end else if (!active) begin
         beat   <= '0;
         addr_q <= ext_base + EAW'({chunk, {CHW{1'b0}}});
      end else begin
         beat   <= beat + CHW'(1);
      end
   end

   assign ext_wvalid = active;
   assign ext_waddr  = addr_q;
   assign ext_wdata  = words[beat];
   assign ext_wlast  = active && (beat == CHW'(CHUNK - 1));
   assign burst_end  = ext_wlast;

   // R6: burst address is held and beats continue until the last one
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wvalid && !ext_wlast) |=> (ext_wvalid && $stable(ext_waddr)));
   // R5: a burst always opens on beat zero
   p_first_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_wvalid) |-> beat == '0);

endmodule

// File: rtl/stat_mirror_scanner.sv
module stat_mirror_scanner
   import sms_pkg::*;
#(
   parameter int DW        = 32,
   parameter int CNT_WORDS = 512,
   parameter int REG_WORDS = 64,
   parameter int CHUNK     = 8,
   parameter int EAW       = 24,
   parameter int IW        = 24,
   parameter int LOC_AW    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IW-1:0]     interval_cycles,
   input  logic [EAW-1:0]    ext_base,
   input  logic              fg_busy,
   output logic              st_rd_en,
   output logic              st_rd_bank,
   output logic [LOC_AW-1:0] st_rd_addr,
   input  logic [DW-1:0]     st_rd_data,
   output logic              ext_wvalid,
   output logic [EAW-1:0]    ext_waddr,
   output logic [DW-1:0]     ext_wdata,
   output logic              ext_wlast,
   input  logic              ext_ack,
   output logic              sweep_done
);

   localparam int CHW    = $clog2(CHUNK);
   localparam int NCH_C  = CNT_WORDS / CHUNK;
   localparam int NCH_R  = REG_WORDS / CHUNK;
   localparam int NCHUNK = NCH_C + NCH_R;
   localparam int CW     = $clog2(NCHUNK);
   localparam int NEED_AW = $clog2(larger_of(CNT_WORDS, REG_WORDS));
   localparam logic [CW-1:0] LAST = CW'(NCHUNK - 1);

   generate
      if (CHUNK < 2 || (1 << CHW) != CHUNK) begin : g_bad_chunk
         $error("CHUNK must be a power of two of at least 2");
      end
      if ((CNT_WORDS % CHUNK) != 0 || (REG_WORDS % CHUNK) != 0) begin : g_bad_split
         $error("store sizes must be whole multiples of CHUNK");
      end
      if (NCH_C < 1) begin : g_no_counters
         $error("counter store must hold at least one piece");
      end
      if (LOC_AW < NEED_AW) begin : g_bad_law
         $error("LOC_AW too narrow for the local stores");
      end
      if (EAW < CW + CHW) begin : g_bad_eaw
         $error("EAW too narrow for the sweep span");
      end
   endgenerate

   scan_state_e               state;
   logic [CW-1:0]             chunk;
   logic                      pend;
   logic                      tick;
   logic                      start;
   logic                      rd_done;
   logic                      burst_end;
   logic [CHUNK-1:0][DW-1:0]  words;

   sms_pacer #(.IW(IW)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .interval (interval_cycles),
      .tick     (tick)
   );

   sms_chunk_reader #(
      .DW(DW), .CHUNK(CHUNK), .NCH_C(NCH_C), .NCH_R(NCH_R), .CW(CW), .LAW(LOC_AW)
   ) u_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (state == SC_READ),
      .chunk      (chunk),
      .fg_busy    (fg_busy),
      .st_rd_data (st_rd_data),
      .st_rd_en   (st_rd_en),
      .st_rd_bank (st_rd_bank),
      .st_rd_addr (st_rd_addr),
      .done       (rd_done),
      .words      (words)
   );

   sms_burst_writer #(
      .DW(DW), .CHUNK(CHUNK), .CW(CW), .EAW(EAW)
   ) u_writer (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (state == SC_BURST),
      .chunk      (chunk),
      .ext_base   (ext_base),
      .words      (words),
      .ext_wvalid (ext_wvalid),
      .ext_waddr  (ext_waddr),
      .ext_wdata  (ext_wdata),
      .ext_wlast  (ext_wlast),
      .burst_end  (burst_end)
   );

   assign start = (state == SC_IDLE) && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SC_IDLE;
         chunk      <= '0;
         pend       <= 1'b0;
         sweep_done <= 1'b0;
      end else begin
         pend       <= tick | (pend & !start);
         sweep_done <= 1'b0;
         case (state)
            SC_IDLE:  if (pend)      state <= SC_READ;
            SC_READ:  if (rd_done)   state <= SC_BURST;
            SC_BURST: if (burst_end) state <= SC_WAIT;
            SC_WAIT: begin
               if (ext_ack) begin
                  state      <= SC_IDLE;
                  chunk      <= (chunk == LAST) ? '0 : chunk + CW'(1);
                  sweep_done <= (chunk == LAST);
               end
            end
            default: state <= SC_IDLE;
         endcase
      end
   end

   // R2: no tick pending means the scanner stays idle
   p_start_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_IDLE && !pend) |=> state == SC_IDLE);
   // R3: piece number stays within the sweep
   p_chunk_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chunk <= LAST);
   // R7: without acknowledge the scanner keeps waiting on the same piece
   p_wait_for_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_WAIT && !ext_ack) |=> (state == SC_WAIT && $stable(chunk)));
   // R8: sweep pulse lasts one cycle and coincides with the wrap to piece 0
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |=> !sweep_done);
   p_done_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |-> (chunk == '0 && state == SC_IDLE));

endmodule

// File: tb/stat_mirror_scanner_test.sv
`timescale 1ns/1ps
module stat_mirror_scanner_test;

   localparam int NCH_C  = 64;
   localparam int NCHUNK = 72;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] interval_cycles = '0;
   logic [23:0] ext_base = '0;
   logic        fg_busy = 1'b0;
   logic        st_rd_en;
   logic        st_rd_bank;
   logic [8:0]  st_rd_addr;
   logic [31:0] st_rd_data = '0;
   logic        ext_wvalid;
   logic [23:0] ext_waddr;
   logic [31:0] ext_wdata;
   logic        ext_wlast;
   logic        ext_ack = 1'b0;
   logic        sweep_done;

   always #10 clk = ~clk;

   stat_mirror_scanner uut (
      .clk(clk), .rst_n(rst_n), .interval_cycles(interval_cycles), .ext_base(ext_base),
      .fg_busy(fg_busy), .st_rd_en(st_rd_en), .st_rd_bank(st_rd_bank),
      .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data), .ext_wvalid(ext_wvalid),
      .ext_waddr(ext_waddr), .ext_wdata(ext_wdata), .ext_wlast(ext_wlast),
      .ext_ack(ext_ack), .sweep_done(sweep_done)
   );

   int checks = 0;
   int errors = 0;
   int seed = 0;
   int unsigned lfsr = 32'h1234_5678;
   int cyc = 0;
   int gcyc = 0;
   bit timed_out = 0;

   // bench state of the reference model
   int rd_chunk, rd_word, wr_chunk, beat, ack_cd, acks, last_ack_cyc;
   bit waiting, done_due, first_start;
   int ebuf [8];
   bit busy_on, spur_on;
   int pace_mode, cur_iv, max_delay;

   function automatic logic [31:0] memval(input logic bank, input logic [8:0] a, input int s);
      return (bank ? 32'h5A00_0000 : 32'hC300_0000) ^ (32'(s) << 12) ^ (32'(a) * 32'd3 + 32'd1);
   endfunction

   function automatic int rnd();
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      return int'(lfsr >> 16);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   always @(posedge clk) begin
      if (st_rd_en) st_rd_data <= memval(st_rd_bank, st_rd_addr, seed);
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic step();
      bit exp_done, wait_now, ack_now;
      int exp_bank, exp_addr, exp_start, rel;
      @(negedge clk);
      gcyc++;
      exp_done = done_due;
      done_due = 0;
      wait_now = waiting;
      ack_now  = 0;
      fg_busy  = busy_on && (rnd() % 100 < 30);
      if (fg_busy && (rnd() % 4 == 0)) seed++;   // foreground changes store contents
      if (waiting) begin
         if (ack_cd == 0) begin
            ack_now      = 1;
            waiting      = 0;
            done_due     = (wr_chunk == NCHUNK - 1);
            last_ack_cyc = cyc;
            wr_chunk     = (wr_chunk + 1) % NCHUNK;
            acks++;
         end else begin
            ack_cd--;
         end
      end
      ext_ack = ack_now || (!wait_now && spur_on && (rnd() % 8 == 0));   // R7 stray acks
      #1;
      chk(sweep_done == exp_done, "R8 sweep_done", longint'(sweep_done), longint'(exp_done));
      if (fg_busy) chk(!st_rd_en, "R4 read while busy", longint'(st_rd_en), 0);
      if (wait_now) chk(!st_rd_en && !ext_wvalid, "R7 activity before ack",
                        longint'(st_rd_en | ext_wvalid), 0);
      if (st_rd_en) begin
         if (rd_word == 0) begin
            if (pace_mode == 1) begin
               rel = cyc - 2 - (cur_iv - 1);
               exp_start = (rel < 0) ? cur_iv + 1 : (rel / cur_iv) * cur_iv + cur_iv + 1;
               chk(rel >= 0 && (rel % cur_iv) == 0, "R2 paced start", cyc, exp_start);
            end else if (pace_mode == 2) begin
               exp_start = first_start ? 2 : last_ack_cyc + 2;
               chk(cyc == exp_start, "R2 back-to-back start", cyc, exp_start);
            end
            first_start = 0;
         end
         exp_bank = (rd_chunk >= NCH_C) ? 1 : 0;
         exp_addr = (rd_chunk - (exp_bank ? NCH_C : 0)) * 8 + rd_word;
         chk(int'(st_rd_bank) == exp_bank, "R3 bank", longint'(st_rd_bank), exp_bank);
         chk(int'(st_rd_addr) == exp_addr, "R3 address", longint'(st_rd_addr), exp_addr);
         ebuf[rd_word] = int'(memval(st_rd_bank, st_rd_addr, seed));
         rd_word++;
         if (rd_word == 8) begin
            rd_word  = 0;
            rd_chunk = (rd_chunk + 1) % NCHUNK;
         end
      end
      if (beat > 0) chk(ext_wvalid, "R5 burst gap", longint'(ext_wvalid), 1);
      if (ext_wvalid) begin
         exp_addr = (int'(ext_base) + wr_chunk * 8) & 24'hFF_FFFF;
         chk(int'(ext_waddr) == exp_addr, "R6 burst address", longint'(ext_waddr), exp_addr);
         chk(int'(ext_wdata) == ebuf[beat], "R5 beat data", longint'(ext_wdata), longint'(ebuf[beat]));
         chk(ext_wlast == (beat == 7), "R5 last flag", longint'(ext_wlast), longint'(beat == 7));
         beat++;
         if (beat == 8) begin
            beat    = 0;
            waiting = 1;
            ack_cd  = (max_delay == 0) ? 0 : rnd() % (max_delay + 1);
         end
      end
   endtask

   task automatic run_phase(input int iv, input int base, input bit busy, input bit spur,
                            input int pace, input int maxd, input int target);
      @(negedge clk);
      rst_n = 0;
      fg_busy = 0;
      ext_ack = 0;
      interval_cycles = 24'(iv);
      ext_base = 24'(base);
      busy_on = busy; spur_on = spur; pace_mode = pace; max_delay = maxd;
      cur_iv = (iv == 0) ? 1 : iv;
      rd_chunk = 0; rd_word = 0; wr_chunk = 0; beat = 0; ack_cd = 0; acks = 0;
      waiting = 0; done_due = 0; first_start = 1; last_ack_cyc = 0;
      repeat (3) @(negedge clk);
      #1;
      chk(!st_rd_en, "R1 reset read", longint'(st_rd_en), 0);
      chk(!ext_wvalid, "R1 reset write", longint'(ext_wvalid), 0);
      chk(!sweep_done, "R1 reset done", longint'(sweep_done), 0);
      @(negedge clk);
      rst_n = 1;
      while (acks < target && !timed_out) begin
         step();
         if (gcyc > 150000) begin
            timed_out = 1;
            chk(0, "R2 watchdog progress", acks, target);
         end
      end
   endtask

   initial begin
      // paced sweep past the wrap, quiet port, prompt acknowledge
      run_phase(40, 24'h00_1000, 0, 0, 1, 0, 74);
      // fast pacing, foreground contention, stray acks, address wrap near top
      run_phase(3, 24'hFF_FE00, 1, 1, 0, 6, 146);
      // interval zero acts as one: pieces run back to back
      run_phase(0, 24'h12_3450, 0, 1, 2, 2, 12);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule